// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Pulse Generator

This block turns a square-wave oscillator signal into two complementary gate enables, one for the low-side switch and one for the high-side switch of a half bridge. Every oscillator edge ends the current half-cycle. Both enables then stay low for a fixed gap before the other side turns on, so the two switches never conduct together. Each side is on for half the oscillator period, minus the gap.

Start-up is ordered. After enable, the first pulse always goes to the low side. The high side stays off until a separate floating-supply-ready input, synchronised into the clock domain, reports that its supply is charged. The low side keeps switching while it waits. Disabling the block drops both enables on the next clock. So does a force-off request, and force-off stays latched until enable is removed. One-cycle strobes mark each low-side rising edge, each low-side falling edge and each high-side falling edge, for the sensing logic alongside.

Top module: `hbdt_gate_driver`

## Requirements
- R1: After enable is sampled high at a clock edge, with no force-off pending, the low-side enable rises exactly DEAD_CLKS clocks later. The first pulse after enable is always on the low side, never on the high side.
- R2: The high-side enable stays low while the synchronised supply-ready input is low, and the low side keeps pulsing during that time. Once ready is high, high-side pulses appear in the high-side half-cycles.
- R3: The low-side and high-side enables are never high in the same cycle. At least DEAD_CLKS clocks with both enables low separate one side turning off from the other side turning on. In steady running the gap is exactly DEAD_CLKS.
- R4: With an oscillator half-period of H clocks, where H is greater than DEAD_CLKS, each steady-state pulse on either side lasts H - DEAD_CLKS clocks.
- R5: In reset both enables and all three strobes are low. Enable low forces both enables low at the next clock edge, even mid-pulse.
- R6: A force-off request forces both enables low at the next clock edge, even mid-pulse. The block then stays off while enable remains high. Only after enable goes low and high again does it restart, and the restart begins with the low side.
- R7: Each strobe is high for exactly the one cycle in which its enable has just changed. The strobes are low-side rising, low-side falling and high-side falling.
- R8: If the supply-ready input drops during a high-side pulse, the high-side enable falls at the third clock edge after the drop: two synchroniser stages, then the output register. If ready returns during the same half-cycle, that half-cycle's pulse does not restart.
- R9: An oscillator edge that arrives during a gap between pulses switches to the opposite gap and restarts its count. The exception is the start-up gap after enable, which ignores edges. So when the half-period is no longer than DEAD_CLKS, only the single start-up low-side pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Oscillator square wave; each edge ends a half-cycle |
| en_i | input | 1 | Run enable; low holds both sides off and clears a latched force-off |
| hs_rdy_i | input | 1 | High-side floating supply ready (asynchronous) |
| kill_i | input | 1 | Force-off request, latched until enable drops |
| lo_o | output | 1 | Low-side gate enable |
| ho_o | output | 1 | High-side gate enable |
| lo_rise_o | output | 1 | One-cycle strobe on low-side turn-on |
| lo_fall_o | output | 1 | One-cycle strobe on low-side turn-off |
| ho_fall_o | output | 1 | One-cycle strobe on high-side turn-off |

## Verification
The bench builds the block with DEAD_CLKS = 3 and the default two-stage synchroniser. A gap that short lets the bench sweep every oscillator half-period from 4 to 12 clocks in a few hundred cycles, and at each one compare pulse widths and gaps with the closed-form values. The same short gap makes a half-period of 2 land inside every gap, which exercises the gap-restart and start-up-ignore path of R9. The two-stage synchroniser keeps the supply-ready latency of R8 at a fixed, countable three clock edges.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

  // Phases of the half-bridge sequence
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_GAP_LO = 3'd1,
    PH_LO     = 3'd2,
    PH_GAP_HI = 3'd3,
    PH_HI     = 3'd4
  } phase_e;

  // True for the two both-off intervals
  function automatic logic is_gap(phase_e p);
    return (p == PH_GAP_LO) || (p == PH_GAP_HI);
  endfunction

  // A gap of 'dead' clocks has run out when the elapsed count reaches dead-1
  function automatic logic gap_expired(int unsigned elapsed, int unsigned dead);
    return (elapsed + 1) >= dead;
  endfunction

  // Steady-state width of one pulse for a half-period of 'half' clocks
  function automatic int unsigned pulse_width(int unsigned half, int unsigned dead);
    return (half > dead) ? (half - dead) : 0;
  endfunction

  // Counter width able to hold values 0 .. limit-1
  function automatic int unsigned count_width(int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hbdt_gap_timer.sv
module hbdt_gap_timer #(
  parameter int unsigned DEAD_CLKS = 100,
  parameter int unsigned CNT_W     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic expired_o
);

  import hbdt_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_i && gap_expired(32'(cnt_q), DEAD_CLKS);

endmodule

// File: rtl/hbdt_phase_fsm.sv
module hbdt_phase_fsm
  import hbdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en_i,
  input  logic   kill_i,
  input  logic   osc_edge_i,
  input  logic   gap_done_i,
  output phase_e phase_o,
  output phase_e phase_nxt_o,
  output logic   gap_restart_o
);

  phase_e phase_q;
  phase_e phase_d;
  logic   fault_q;
  logic   first_q;
  logic   halt;

  assign halt = !en_i || kill_i || fault_q;

  // Force-off latch, cleared only by dropping enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (!en_i) begin
      fault_q <= 1'b0;
    end else if (kill_i) begin
      fault_q <= 1'b1;
    end
  end

  always_comb begin
    phase_d = phase_q;
    if (halt) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE:   phase_d = PH_GAP_LO;
        PH_GAP_LO: begin
          if (osc_edge_i && !first_q) phase_d = PH_GAP_HI;
          else if (gap_done_i)        phase_d = PH_LO;
        end
        PH_LO:     if (osc_edge_i) phase_d = PH_GAP_HI;
        PH_GAP_HI: begin
          if (osc_edge_i)      phase_d = PH_GAP_LO;
          else if (gap_done_i) phase_d = PH_HI;
        end
        PH_HI:     if (osc_edge_i) phase_d = PH_GAP_LO;
        default:   phase_d = PH_IDLE;
      endcase
    end
  end

  // Start-up marker: the gap entered from idle ignores oscillator edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
    end else if ((phase_q == PH_IDLE) && (phase_d == PH_GAP_LO)) begin
      first_q <= 1'b1;
    end else if (phase_d != PH_GAP_LO) begin
      first_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_o       = phase_q;
  assign phase_nxt_o   = phase_d;
  assign gap_restart_o = is_gap(phase_d) && (phase_d != phase_q);

endmodule

// File: rtl/hbdt_gate_out.sv
module hbdt_gate_out
  import hbdt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_i,
  input  phase_e phase_nxt_i,
  input  logic   rdy_s_i,
  output logic   lo_o,
  output logic   ho_o,
  output logic   lo_rise_o,
  output logic   lo_fall_o,
  output logic   ho_fall_o
);

  logic lo_d;
  logic ho_d;
  logic lo_q;
  logic ho_q;
  logic lo_rise_q;
  logic lo_fall_q;
  logic ho_fall_q;

  assign lo_d = (phase_nxt_i == PH_LO);
  // High side starts only at the head of its phase and drops when ready is lost
  assign ho_d = (phase_nxt_i == PH_HI) && rdy_s_i && ((phase_i != PH_HI) || ho_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= 1'b0;
      ho_q      <= 1'b0;
      lo_rise_q <= 1'b0;
      lo_fall_q <= 1'b0;
      ho_fall_q <= 1'b0;
    end else begin
      lo_q      <= lo_d;
      ho_q      <= ho_d;
      lo_rise_q <= lo_d && !lo_q;
      lo_fall_q <= !lo_d && lo_q;
      ho_fall_q <= !ho_d && ho_q;
    end
  end

  assign lo_o      = lo_q;
  assign ho_o      = ho_q;
  assign lo_rise_o = lo_rise_q;
  assign lo_fall_o = lo_fall_q;
  assign ho_fall_o = ho_fall_q;

endmodule

// File: rtl/hbdt_gate_driver.sv
module hbdt_gate_driver
  import hbdt_pkg::*;
#(
  parameter int unsigned DEAD_CLKS   = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  input  logic en_i,
  input  logic hs_rdy_i,
  input  logic kill_i,
  output logic lo_o,
  output logic ho_o,
  output logic lo_rise_o,
  output logic lo_fall_o,
  output logic ho_fall_o
);

  localparam int unsigned GAP_W = count_width(DEAD_CLKS);

  // Named internal events
  logic   osc_s;
  logic   osc_d_q;
  logic   osc_edge;
  logic   rdy_s;
  logic   gap_restart;
  logic   gap_done;
  phase_e phase_cur;
  phase_e phase_nxt;

  hbdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) osc_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (osc_i),
    .q_o   (osc_s)
  );

  hbdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) rdy_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hs_rdy_i),
    .q_o   (rdy_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_d_q <= 1'b0;
    end else begin
      osc_d_q <= osc_s;
    end
  end

  assign osc_edge = osc_s ^ osc_d_q;

  hbdt_phase_fsm fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .kill_i        (kill_i),
    .osc_edge_i    (osc_edge),
    .gap_done_i    (gap_done),
    .phase_o       (phase_cur),
    .phase_nxt_o   (phase_nxt),
    .gap_restart_o (gap_restart)
  );

  hbdt_gap_timer #(.DEAD_CLKS(DEAD_CLKS), .CNT_W(GAP_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (gap_restart),
    .run_i     (is_gap(phase_cur)),
    .expired_o (gap_done)
  );

  hbdt_gate_out out_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_i     (phase_cur),
    .phase_nxt_i (phase_nxt),
    .rdy_s_i     (rdy_s),
    .lo_o        (lo_o),
    .ho_o        (ho_o),
    .lo_rise_o   (lo_rise_o),
    .lo_fall_o   (lo_fall_o),
    .ho_fall_o   (ho_fall_o)
  );

endmodule

// File: rtl/hbdt_gate_driver_chk.sv
module hbdt_gate_driver_chk #(
  parameter int unsigned DEAD_CLKS = 100
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic kill_i,
  input logic rdy_s,
  input logic lo_o,
  input logic ho_o,
  input logic lo_rise_o,
  input logic lo_fall_o,
  input logic ho_fall_o
);

  localparam int unsigned CW = $clog2(DEAD_CLKS + 1);
  localparam logic [CW-1:0] CAP = CW'(DEAD_CLKS);

  logic [CW-1:0] lo_off_cnt;
  logic [CW-1:0] ho_off_cnt;
  logic          lo_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_off_cnt <= '0;
      ho_off_cnt <= '0;
      lo_seen    <= 1'b0;
    end else begin
      lo_off_cnt <= lo_o ? '0 : ((lo_off_cnt == CAP) ? CAP : lo_off_cnt + 1'b1);
      ho_off_cnt <= ho_o ? '0 : ((ho_off_cnt == CAP) ? CAP : ho_off_cnt + 1'b1);
      if (!en_i)     lo_seen <= 1'b0;
      else if (lo_o) lo_seen <= 1'b1;
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_o && ho_o));

  // R3
  ho_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ho_o) |-> (lo_off_cnt == CAP));

  // R3
  lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_o) |-> (ho_off_cnt == CAP));

  // R1
  first_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ho_o) |-> lo_seen);

  // R2
  ho_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ho_o |-> $past(rdy_s));

  // R5
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!lo_o && !ho_o));

  // R6
  kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (!lo_o && !ho_o));

  // R7
  lo_rise_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rise_o |-> (lo_o && !$past(lo_o)));

  // R7
  lo_rise_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_o) |-> lo_rise_o);

  // R7
  lo_fall_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_fall_o |-> (!lo_o && $past(lo_o)));

  // R7
  ho_fall_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ho_o) |-> ho_fall_o);

endmodule

bind hbdt_gate_driver hbdt_gate_driver_chk #(.DEAD_CLKS(DEAD_CLKS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_i),
  .kill_i    (kill_i),
  .rdy_s     (rdy_s),
  .lo_o      (lo_o),
  .ho_o      (ho_o),
  .lo_rise_o (lo_rise_o),
  .lo_fall_o (lo_fall_o),
  .ho_fall_o (ho_fall_o)
);

// File: tb/hbdt_gate_driver_tb_top.sv
module hbdt_gate_driver_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 3;
  localparam int WATCHDOG   = 150000;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic osc   = 1'b0;
  logic en    = 1'b0;
  logic rdy   = 1'b0;
  logic kill  = 1'b0;
  logic lo, ho, lr, lf, hf;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hbdt_gate_driver #(.DEAD_CLKS(DEAD), .SYNC_STAGES(2)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_i     (osc),
    .en_i      (en),
    .hs_rdy_i  (rdy),
    .kill_i    (kill),
    .lo_o      (lo),
    .ho_o      (ho),
    .lo_rise_o (lr),
    .lo_fall_o (lf),
    .ho_fall_o (hf)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Oscillator: toggles every osc_h clocks
  bit osc_run = 1'b0;
  int osc_h   = 10;
  int osc_cnt = 0;
  always @(negedge clk) begin
    if (osc_run) begin
      if (osc_cnt >= osc_h - 1) begin
        osc     <= ~osc;
        osc_cnt <= 0;
      end else begin
        osc_cnt <= osc_cnt + 1;
      end
    end
  end

  // Output monitor
  bit   mon_on    = 1'b0;
  bit   steady    = 1'b0;
  bit   first_chk = 1'b0;
  int   lo_len = 0, ho_len = 0, gap_len = 0;
  int   lo_rises = 0, ho_samples = 0;
  logic lo_p = 1'b0, ho_p = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      check(!(lo && ho), "R3 overlap", int'(lo && ho), 0);
      if (lo && !lo_p) begin
        check(lr == 1'b1, "R7 lo_rise strobe", int'(lr), 1);
        if (steady) check(gap_len == DEAD, "R3 gap before LO", gap_len, DEAD);
        if (first_chk) begin
          check(1'b1, "R1 first pulse on LO", 1, 1);
          first_chk = 1'b0;
        end
        lo_rises++;
      end
      if (!lo && lo_p) begin
        check(lf == 1'b1, "R7 lo_fall strobe", int'(lf), 1);
        if (steady) check(lo_len == osc_h - DEAD, "R4 LO width", lo_len, osc_h - DEAD);
      end
      if (ho && !ho_p) begin
        if (first_chk) begin
          check(1'b0, "R1 HO before LO", 1, 0);
          first_chk = 1'b0;
        end
        if (steady) check(gap_len == DEAD, "R3 gap before HO", gap_len, DEAD);
      end
      if (!ho && ho_p) begin
        check(hf == 1'b1, "R7 ho_fall strobe", int'(hf), 1);
        if (steady) check(ho_len == osc_h - DEAD, "R4 HO width", ho_len, osc_h - DEAD);
      end
      if (lr && !(lo && !lo_p)) check(1'b0, "R7 stray lo_rise", 1, 0);
      if (lf && !(!lo && lo_p)) check(1'b0, "R7 stray lo_fall", 1, 0);
      if (hf && !(!ho && ho_p)) check(1'b0, "R7 stray ho_fall", 1, 0);
      if (ho) ho_samples++;
    end
    lo_len  = lo ? lo_len + 1 : 0;
    ho_len  = ho ? ho_len + 1 : 0;
    gap_len = (!lo && !ho) ? gap_len + 1 : 0;
    lo_p    = lo;
    ho_p    = ho;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R5 reset state
    check({lo, ho, lr, lf, hf} == 5'b0, "R5 reset outputs", int'({lo, ho, lr, lf, hf}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on  = 1'b1;
    osc_h   = 10;
    osc_run = 1'b1;
    repeat (7) @(negedge clk);

    // R1 start-up latency, R2 high side held while not ready
    en = 1'b1; first_chk = 1'b1; lo_rises = 0; ho_samples = 0;
    repeat (DEAD) @(negedge clk);
    check(lo == 1'b0, "R1 LO not yet", int'(lo), 0);
    @(negedge clk);
    check(lo == 1'b1, "R1 LO after dead time", int'(lo), 1);
    repeat (80) @(negedge clk);
    check(lo_rises >= 3, "R2 LO keeps switching", lo_rises, 3);
    check(ho_samples == 0, "R2 HO held without ready", ho_samples, 0);

    // R4 / R3 sweep of half-periods with ready high
    rdy = 1'b1;
    for (int h = 4; h <= 12; h++) begin
      steady = 1'b0;
      osc_h  = h;
      repeat (4 * h + 10) @(negedge clk);
      steady = 1'b1; ho_samples = 0; lo_rises = 0;
      repeat (8 * h) @(negedge clk);
      check(ho_samples > 0, "R2 HO runs when ready", ho_samples, 1);
      check(lo_rises >= 3, "R4 LO pulses in sweep", lo_rises, 3);
    end
    steady = 1'b0;

    // R8 ready loss mid high-side pulse
    osc_h = 20;
    repeat (50) @(negedge clk);
    while (!(ho && !ho_p)) @(negedge clk);
    repeat (2) @(negedge clk);
    rdy = 1'b0;
    repeat (2) @(negedge clk);
    check(ho == 1'b1, "R8 HO holds through sync", int'(ho), 1);
    @(negedge clk);
    check(ho == 1'b0, "R8 HO drops on ready loss", int'(ho), 0);
    rdy = 1'b1;
    repeat (5) @(negedge clk);
    check(ho == 1'b0, "R8 no restart in same phase", int'(ho), 0);
    ho_samples = 0;
    repeat (60) @(negedge clk);
    check(ho_samples > 0, "R8 HO resumes next phase", ho_samples, 1);

    // R6 force-off mid low-side pulse, latched
    while (!(lo && !lo_p)) @(negedge clk);
    @(negedge clk);
    kill = 1'b1;
    @(negedge clk);
    check({lo, ho} == 2'b00, "R6 force-off next clock", int'({lo, ho}), 0);
    kill = 1'b0; lo_rises = 0; ho_samples = 0;
    repeat (60) @(negedge clk);
    check(lo_rises == 0, "R6 latched LO off", lo_rises, 0);
    check(ho_samples == 0, "R6 latched HO off", ho_samples, 0);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1; first_chk = 1'b1; lo_rises = 0;
    repeat (60) @(negedge clk);
    check(lo_rises >= 2, "R6 restart after enable cycle", lo_rises, 2);
    check(first_chk == 1'b0, "R1 pulse seen after restart", int'(first_chk), 0);

    // R5 disable mid high-side pulse
    while (!(ho && !ho_p)) @(negedge clk);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check({lo, ho} == 2'b00, "R5 disable next clock", int'({lo, ho}), 0);
    lo_rises = 0; ho_samples = 0;
    repeat (30) @(negedge clk);
    check(lo_rises == 0 && ho_samples == 0, "R5 stays off while disabled", lo_rises + ho_samples, 0);

    // R9 half-period no longer than dead time
    osc_h = 2;
    repeat (4) @(negedge clk);
    en = 1'b1; first_chk = 1'b1; lo_rises = 0; ho_samples = 0;
    repeat (60) @(negedge clk);
    check(lo_rises == 1, "R9 single start-up LO pulse", lo_rises, 1);
    check(ho_samples == 0, "R9 no HO with short half-period", ho_samples, 0);

    en = 1'b0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule